// File: doc/BRIEF.md
# Regulator Enable and Shutdown Sequencer

This block is the digital start-up and shutdown control of a multiphase voltage-regulator controller. It takes the digitised run conditions as inputs: a bias-supply-good flag, the enable comparator output and a logic-level enable. It also decodes the 6-bit voltage code for the two reserved no-load values. From these it decides when the phase drivers may switch, runs a soft-start ramp counted in switching cycles, picks the over-voltage trip level and reports power-good.

An over-voltage event is latched. The drivers then stay off until the bias supply drops. A reserved no-load code does not stop the drivers at once. The block waits a fixed number of switching cycles, then moves the trip level to its shutdown setting and stops the drivers on the same edge. Any ordinary code starts a fresh soft-start.

Top module: `vrseq_top`

## Requirements
- R1: While `rst` is high, every output is registered to its off value: `pwm_en`=0, `trip_sel_off`=1, `pgood`=0, `ss_ramp`=0.
- R2: In shutdown, if `supply_ok`, `cmp_en` and `logic_en` are all 1, `ov_fault` is 0, no over-voltage is latched and `vid` is not a no-load code, then at the next clock edge `pwm_en` goes to 1, `trip_sel_off` goes to 0 and `ss_ramp` restarts from 0.
- R3: During soft-start, `ss_ramp` rises by one on each edge where `cyc_stb` is 1. It holds at RAMP_TOP. On the first edge after it reaches RAMP_TOP, the block enters the running state.
- R4: The no-load codes are all ones (6'h3F) and all ones with bit 0 clear (6'h3E). While one is present, `pwm_en` stays 1 and `trip_sel_off` stays 0 until the edge that sees the NL_CYC-th `cyc_stb`. At that edge `pwm_en` drops to 0, `trip_sel_off` rises to 1 and `ss_ramp` clears, all together.
- R5: An ordinary code seen during the no-load wait, or after a no-load shutdown, starts a new soft-start at the next edge with `ss_ramp`=0.
- R6: `ov_fault`=1 forces shutdown at the next edge. The shutdown is latched and persists after `ov_fault` returns to 0, including while `vid` goes to a no-load code and back.
- R7: `pgood` is 1 only in the running state and only while `in_window` is 1, with one clock of latency. It is 0 during soft-start, during the no-load wait and in shutdown.
- R8: When `supply_ok`, `cmp_en` or `logic_en` goes to 0, the next edge shuts down with no wait for `cyc_stb`.
- R9: The over-voltage latch clears only on an edge where `supply_ok` is 0. After that, restoring the run conditions starts soft-start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Bias supply above power-on threshold |
| cmp_en | input | 1 | Enable comparator output |
| logic_en | input | 1 | Logic-level enable |
| vid | input | VID_W | Voltage code |
| ov_fault | input | 1 | Over-voltage detected |
| in_window | input | 1 | Output voltage inside regulation window |
| cyc_stb | input | 1 | One-clock strobe per switching cycle |
| pwm_en | output | 1 | Drivers may switch; 0 means outputs held high-impedance |
| ss_ramp | output | RAMP_W | Soft-start ramp value |
| trip_sel_off | output | 1 | 1 selects the shutdown over-voltage trip level |
| pgood | output | 1 | Power-good |

## Verification
If the sequencer's state register held a wrong value, `pwm_en` and `trip_sel_off` would show it on the next edge, because both are registered from the next state. A wrong ramp count appears directly on `ss_ramp`. Its effect on `pgood` shows up only once the ramp should have reached RAMP_TOP. A no-load dwell counter that is off by one moves the shutdown edge by one strobe, so the checks sample every cycle of the wait. A latch that fails to hold becomes visible only when the run conditions return. For that reason the bench restores them with `ov_fault` low and a no-load code toggled.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;
  typedef enum logic [1:0] {
    SQ_OFF  = 2'd0,
    SQ_RAMP = 2'd1,
    SQ_RUN  = 2'd2,
    SQ_PARK = 2'd3
  } sq_state_e;
endpackage

// File: rtl/vrseq_gate.sv
module vrseq_gate #(
  parameter int VID_W = 6
) (
  input  logic             supply_ok,
  input  logic             cmp_en,
  input  logic             logic_en,
  input  logic [VID_W-1:0] vid,
  output logic             hard_ok,
  output logic             noload
);
  localparam logic [VID_W-2:0] UPPER_ONES = {(VID_W-1){1'b1}};

  always_comb begin
    hard_ok = supply_ok & cmp_en & logic_en;
    // both reserved codes share all ones above bit 0
    noload  = (vid[VID_W-1:1] == UPPER_ONES);
  end
endmodule

// File: rtl/vrseq_ramp.sv
module vrseq_ramp #(
  parameter int RAMP_W   = 4,
  parameter int RAMP_TOP = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  output logic [RAMP_W-1:0] cnt,
  output logic              done
);
  localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_TOP);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (adv && cnt != TOP)
      cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);

  a_r3_ramp_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
  a_r3_ramp_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
endmodule

// File: rtl/vrseq_dwell.sv
module vrseq_dwell #(
  parameter int NL_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic stb,
  output logic expire
);
  localparam int DW_W = (NL_CYC < 2) ? 1 : $clog2(NL_CYC);
  localparam logic [DW_W-1:0] LAST = DW_W'(NL_CYC - 1);

  logic [DW_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (stb && cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign expire = stb && (cnt == LAST);

  a_r4_dwell_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/vrseq_ovlatch.sv
module vrseq_ovlatch (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic ov_fault,
  output logic ov_lat
);
  always_ff @(posedge clk) begin
    if (rst || !supply_ok)
      ov_lat <= 1'b0;
    else if (ov_fault)
      ov_lat <= 1'b1;
  end

  a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (ov_lat && supply_ok) |=> ov_lat);
  a_r9_latch_clear: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !ov_lat);
endmodule

// File: rtl/vrseq_top.sv
module vrseq_top #(
  parameter int VID_W    = 6,
  parameter int RAMP_W   = 4,
  parameter int RAMP_TOP = 15,
  parameter int NL_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              cmp_en,
  input  logic              logic_en,
  input  logic [VID_W-1:0]  vid,
  input  logic              ov_fault,
  input  logic              in_window,
  input  logic              cyc_stb,
  output logic              pwm_en,
  output logic [RAMP_W-1:0] ss_ramp,
  output logic              trip_sel_off,
  output logic              pgood
);
  import vrseq_pkg::*;

  sq_state_e st, nxt;
  logic hard_ok, noload, ov_lat, ov_trip;
  logic ramp_clr, ramp_adv, ramp_done, dwell_exp;

  vrseq_gate #(.VID_W(VID_W)) u_gate (
    .supply_ok(supply_ok), .cmp_en(cmp_en), .logic_en(logic_en),
    .vid(vid), .hard_ok(hard_ok), .noload(noload)
  );

  vrseq_ovlatch u_ov (
    .clk(clk), .rst(rst), .supply_ok(supply_ok),
    .ov_fault(ov_fault), .ov_lat(ov_lat)
  );

  assign ov_trip = ov_fault | ov_lat;

  always_comb begin
    nxt = st;
    case (st)
      SQ_OFF:  if (!noload) nxt = SQ_RAMP;
      SQ_RAMP: if (noload) nxt = SQ_PARK;
               else if (ramp_done) nxt = SQ_RUN;
      SQ_RUN:  if (noload) nxt = SQ_PARK;
      SQ_PARK: if (!noload) nxt = SQ_RAMP;
               else if (dwell_exp) nxt = SQ_OFF;
      default: nxt = SQ_OFF;
    endcase
    if (!hard_ok || ov_trip)
      nxt = SQ_OFF;
  end

  assign ramp_clr = (nxt == SQ_OFF) || (nxt == SQ_RAMP && st != SQ_RAMP);
  assign ramp_adv = (st == SQ_RAMP) && cyc_stb;

  vrseq_ramp #(.RAMP_W(RAMP_W), .RAMP_TOP(RAMP_TOP)) u_ramp (
    .clk(clk), .rst(rst), .clr(ramp_clr), .adv(ramp_adv),
    .cnt(ss_ramp), .done(ramp_done)
  );

  vrseq_dwell #(.NL_CYC(NL_CYC)) u_dwell (
    .clk(clk), .rst(rst), .clr(st != SQ_PARK), .stb(cyc_stb),
    .expire(dwell_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SQ_OFF;
      pwm_en       <= 1'b0;
      trip_sel_off <= 1'b1;
      pgood        <= 1'b0;
    end else begin
      st           <= nxt;
      pwm_en       <= (nxt != SQ_OFF);
      trip_sel_off <= (nxt == SQ_OFF);
      pgood        <= (nxt == SQ_RUN) && in_window;
    end
  end

  a_r8_hard_off: assert property (@(posedge clk) disable iff (rst)
    !hard_ok |=> !pwm_en);
  a_r6_ov_off: assert property (@(posedge clk) disable iff (rst)
    ov_fault |=> (!pwm_en && trip_sel_off));
  a_r7_pg_needs_pwm: assert property (@(posedge clk) disable iff (rst)
    pgood |-> pwm_en);
  a_r7_pg_window: assert property (@(posedge clk) disable iff (rst)
    !in_window |=> !pgood);
  a_r4_park_keeps_pwm: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_RUN && noload && hard_ok && !ov_trip) |=> pwm_en);
endmodule

// File: tb/sim_vrseq_top.sv
module sim_vrseq_top;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 0, cmp_en = 0, logic_en = 0, ov_fault = 0, in_window = 0, cyc_stb = 0;
  logic [5:0] vid = 6'h10;
  logic pwm_en, trip_sel_off, pgood;
  logic [RW-1:0] ss_ramp;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vrseq_top #(.VID_W(6), .RAMP_W(RW), .RAMP_TOP(3), .NL_CYC(2)) u0 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .cmp_en(cmp_en),
    .logic_en(logic_en), .vid(vid), .ov_fault(ov_fault),
    .in_window(in_window), .cyc_stb(cyc_stb), .pwm_en(pwm_en),
    .ss_ramp(ss_ramp), .trip_sel_off(trip_sel_off), .pgood(pgood)
  );

  // row: {req, supply/cmp/logic, vid, ov/win/stb, exp pwm/sel/pg, exp ramp}
  localparam int NROW = 27;
  localparam logic [22:0] TBL [NROW] = '{
    {4'd2, 3'b111, 6'h10, 3'b010, 3'b100, 4'd0},  // R2 start
    {4'd3, 3'b111, 6'h10, 3'b011, 3'b100, 4'd1},  // R3
    {4'd3, 3'b111, 6'h10, 3'b011, 3'b100, 4'd2},  // R3
    {4'd3, 3'b111, 6'h10, 3'b011, 3'b100, 4'd3},  // R3 top
    {4'd7, 3'b111, 6'h10, 3'b010, 3'b101, 4'd3},  // R7 run + window
    {4'd7, 3'b111, 6'h10, 3'b000, 3'b100, 4'd3},  // R7 out of window
    {4'd4, 3'b111, 6'h3F, 3'b010, 3'b100, 4'd3},  // R4 wait begins
    {4'd4, 3'b111, 6'h3F, 3'b011, 3'b100, 4'd3},  // R4 first strobe
    {4'd4, 3'b111, 6'h3F, 3'b010, 3'b100, 4'd3},  // R4
    {4'd4, 3'b111, 6'h3F, 3'b011, 3'b010, 4'd0},  // R4 second strobe
    {4'd4, 3'b111, 6'h3F, 3'b011, 3'b010, 4'd0},  // R4 stays off
    {4'd5, 3'b111, 6'h3E, 3'b011, 3'b010, 4'd0},  // R5 other no-load
    {4'd5, 3'b111, 6'h05, 3'b011, 3'b100, 4'd0},  // R5 restart
    {4'd3, 3'b111, 6'h05, 3'b011, 3'b100, 4'd1},  // R3
    {4'd4, 3'b111, 6'h3E, 3'b010, 3'b100, 4'd1},  // R4 wait from ramp
    {4'd5, 3'b111, 6'h05, 3'b010, 3'b100, 4'd0},  // R5 abort wait
    {4'd8, 3'b110, 6'h05, 3'b011, 3'b010, 4'd0},  // R8 logic enable
    {4'd2, 3'b111, 6'h05, 3'b010, 3'b100, 4'd0},  // R2
    {4'd8, 3'b101, 6'h05, 3'b010, 3'b010, 4'd0},  // R8 comparator
    {4'd8, 3'b011, 6'h05, 3'b010, 3'b010, 4'd0},  // R8 supply
    {4'd2, 3'b111, 6'h05, 3'b010, 3'b100, 4'd0},  // R2
    {4'd6, 3'b111, 6'h05, 3'b110, 3'b010, 4'd0},  // R6 fault
    {4'd6, 3'b111, 6'h05, 3'b010, 3'b010, 4'd0},  // R6 latched
    {4'd6, 3'b111, 6'h3F, 3'b010, 3'b010, 4'd0},  // R6 no-load code
    {4'd6, 3'b111, 6'h05, 3'b010, 3'b010, 4'd0},  // R6 still latched
    {4'd9, 3'b011, 6'h05, 3'b010, 3'b010, 4'd0},  // R9 supply drop
    {4'd9, 3'b111, 6'h05, 3'b010, 3'b100, 4'd0}   // R9 restart
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input int req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got pwm/sel/pg/ramp=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {pwm_en, trip_sel_off, pgood, 4'(ss_ramp)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(); step();
    chk(1, outs(), 7'b010_0000);  // R1 reset values
    rst = 1'b0;
    step();
    chk(1, outs(), 7'b010_0000);  // R1 stays off with run conditions low

    for (int i = 0; i < NROW; i++) begin
      {supply_ok, cmp_en, logic_en} = TBL[i][18:16];
      vid = TBL[i][15:10];
      {ov_fault, in_window, cyc_stb} = TBL[i][9:7];
      step();
      chk(int'(TBL[i][22:19]), outs(), TBL[i][6:0]);
    end

    // R3 run up to the running state again, then R7 power-good
    cyc_stb = 1'b1;
    step(); step(); step();
    cyc_stb = 1'b0;
    step();
    chk(7, outs(), 7'b101_0011);  // R7

    // R6 fault during the no-load wait
    vid = 6'h3F;
    step();
    chk(4, outs(), 7'b100_0011);  // R4 drivers still on
    ov_fault = 1'b1;
    step();
    chk(6, outs(), 7'b010_0000);  // R6
    ov_fault = 1'b0;
    vid = 6'h05;
    step();
    chk(6, outs(), 7'b010_0000);  // R6 latch holds

    // R9 clear, start, then R1 reset mid-ramp
    supply_ok = 1'b0;
    step();
    supply_ok = 1'b1;
    step();
    chk(9, outs(), 7'b100_0000);  // R9
    cyc_stb = 1'b1;
    step();
    rst = 1'b1;
    step();
    chk(1, outs(), 7'b010_0000);  // R1
    rst = 1'b0;
    cyc_stb = 1'b0;
    step();
    finish_run();
  end
endmodule